// File: doc/BRIEF.md
# Multi-level event interrupt aggregator

This block gathers 96 single-cycle event pulses from peripheral logic into three 32-bit sticky status words. Each of three interrupt request lines has its own group of three 32-bit enable words that together span all 96 events. Any event can therefore be routed to any line, or to several at once. Line A has the highest system priority, then B, then C. A line is asserted while at least one event that it enables is pending.

Software uses a flat 32-bit register port. The status words can be read, and a pending event is acknowledged by writing a one to its bit. The nine enable words can be read and written. For each line, a read-only word reports the lowest-numbered pending event that the line enables, so the handler can pick the event to service without scanning the status words itself.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A pulse on event input n sets bit n%32 of status word n/32, which is read at byte offset 0x00, 0x04 or 0x08 in the same access cycle that follows the clock edge.
- R2: A status bit stays set until software writes a 1 to it. Bits written as 0 in a status write keep their value.
- R3: If an event pulse and a write-one acknowledge reach the same status bit in the same cycle, the bit ends up set. Other bits in that write are still cleared.
- R4: The enable word for line g (A=0, B=1, C=2) and status word w can be read and written at byte offset 0x10 + 0x10*g + 4*w. A write changes only the addressed word.
- R5: Interrupt line g (irq_o bit g) is registered. It goes high one clock after some status bit and its enable bit for line g are both 1, and it goes low one clock after no such bit remains. An enable bit of 0 blocks the event from that line.
- R6: The word at byte offset 0x40 + 4*g reads bit 7 = 1 and bits 6:0 = the lowest event number pending and enabled for line g, with all other bits 0. It reads 0 when no such event exists. Events are numbered 0 to 95 across the three words.
- R7: Reset clears all status and enable words and drives all interrupt lines low.
- R8: A read from an offset outside the map returns 0 and a write to it changes nothing. This covers offsets that are not word aligned, 0x0C, and writes to the read-only vector words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 96 | One single-cycle pulse per event, bit n is event n |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 3 | Interrupt lines, bit 0 = A (highest) to bit 2 = C |

## Verification
The hardest case to reach is an event pulse and a write-one acknowledge that hit the same status bit in the same cycle. The bench first makes the bit pending. It then drives the pulse and a status write in one negedge-aligned cycle, and the write also clears a second bit, so the check shows both the winning bit and the normal clear. Line latency is checked by sampling the line low in the cycle after the status bit appears and high one cycle later. Priority across status words is checked by enabling events in two different words for one line and acknowledging the lower one.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned NUM_WORDS = 3;
  parameter int unsigned NUM_OUTS  = 3;
  localparam int unsigned TOTAL    = WORD_W * NUM_WORDS;
  localparam int unsigned IDX_W    = $clog2(TOTAL);

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } pend_t;

  // lowest set bit across the flattened event space
  function automatic pend_t lowest_pending(input logic [TOTAL-1:0] v);
    pend_t r;
    r = '0;
    for (int i = TOTAL - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.valid = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction

  // read image of a vector word: valid above the index, zeros elsewhere
  function automatic logic [WORD_W-1:0] vec_word(input pend_t p);
    logic [WORD_W-1:0] w;
    w = '0;
    if (p.valid) w[IDX_W:0] = {1'b1, p.idx};
    return w;
  endfunction
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOTAL-1:0] evt_i,
  input  logic [TOTAL-1:0] ack_i,
  output logic [TOTAL-1:0] status_o
);
  logic [TOTAL-1:0] st_q;
  logic [TOTAL-1:0] st_d;

  // a new event overrides a same-cycle acknowledge
  assign st_d = (st_q & ~ack_i) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_i) & ~st_q) == '0));
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~$past(ack_i) & ~st_q) == '0));
  assert_only_events_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(evt_i)) == '0));
  assert_event_beats_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ack_i) != '0) |=> (($past(evt_i & ack_i) & ~st_q) == '0));
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WORDS-1:0] wr_en_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [TOTAL-1:0]     mask_o
);
  logic [TOTAL-1:0] mask_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en_i[w]) mask_q[w*WORD_W +: WORD_W] <= wdata_i;
    end

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i[w] |=> $stable(mask_q[w*WORD_W +: WORD_W]));
    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i[w] |=> (mask_q[w*WORD_W +: WORD_W] == $past(wdata_i)));
  end

  assert_one_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_i));

  assign mask_o = mask_q;
endmodule

// File: rtl/evt_irq_lane.sv
module evt_irq_lane
  import evt_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOTAL-1:0] status_i,
  input  logic [TOTAL-1:0] mask_i,
  output pend_t            pend_o,
  output logic             irq_o
);
  logic [TOTAL-1:0] enabled;
  pend_t            pend;
  logic             irq_q;

  assign enabled = status_i & mask_i;
  assign pend    = lowest_pending(enabled);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend.valid;
  end

  assign pend_o = pend;
  assign irq_o  = irq_q;

  assert_vec_points_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend.valid |-> (status_i[pend.idx] && mask_i[pend.idx]));
  assert_vec_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pend.valid |-> (int'(pend.idx) < TOTAL));
  assert_irq_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(pend.valid)));
  assert_blocked_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & mask_i) == '0) |=> !irq_q);
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_agg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TOTAL-1:0]    evt_pulse_i,
  input  logic [7:0]          bus_addr_i,
  input  logic                bus_wr_i,
  input  logic [WORD_W-1:0]   bus_wdata_i,
  output logic [WORD_W-1:0]   bus_rdata_o,
  output logic [NUM_OUTS-1:0] irq_o
);
  localparam int unsigned STATUS_BLK = 0;
  localparam int unsigned MASK_BLK0  = 1;
  localparam int unsigned VEC_BLK    = MASK_BLK0 + NUM_OUTS;

  // address fields
  logic       aligned;
  logic [1:0] word_sel;
  logic [3:0] blk_sel;
  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign word_sel = bus_addr_i[3:2];
  assign blk_sel  = bus_addr_i[7:4];

  logic word_ok;
  logic status_hit;
  logic [NUM_OUTS-1:0] mask_hit;
  logic [NUM_OUTS-1:0] vec_hit;
  assign word_ok    = aligned && (int'(word_sel) < NUM_WORDS);
  assign status_hit = word_ok && (int'(blk_sel) == STATUS_BLK);

  logic [TOTAL-1:0]    status;
  logic [TOTAL-1:0]    ack_vec;
  logic [TOTAL-1:0]    mask  [NUM_OUTS];
  pend_t               pend  [NUM_OUTS];
  logic [NUM_WORDS-1:0] mask_we [NUM_OUTS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_ack
    assign ack_vec[w*WORD_W +: WORD_W] =
      (bus_wr_i && status_hit && (int'(word_sel) == w)) ? bus_wdata_i : '0;
  end

  evt_status_bank u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_pulse_i),
    .ack_i    (ack_vec),
    .status_o (status)
  );

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_line
    assign mask_hit[g] = word_ok && (int'(blk_sel) == MASK_BLK0 + g);
    assign vec_hit[g]  = aligned && (int'(blk_sel) == VEC_BLK) && (int'(word_sel) == g);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_we
      assign mask_we[g][w] = bus_wr_i && mask_hit[g] && (int'(word_sel) == w);
    end

    evt_mask_bank u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (mask_we[g]),
      .wdata_i (bus_wdata_i),
      .mask_o  (mask[g])
    );

    evt_irq_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status),
      .mask_i   (mask[g]),
      .pend_o   (pend[g]),
      .irq_o    (irq_o[g])
    );
  end

  // read mux
  logic any_hit;
  always_comb begin
    bus_rdata_o = '0;
    any_hit     = status_hit;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (status_hit && int'(word_sel) == w) bus_rdata_o = status[w*WORD_W +: WORD_W];
    end
    for (int g = 0; g < NUM_OUTS; g++) begin
      if (mask_hit[g] || vec_hit[g]) any_hit = 1'b1;
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (mask_hit[g] && int'(word_sel) == w) bus_rdata_o = mask[g][w*WORD_W +: WORD_W];
      end
      if (vec_hit[g]) bus_rdata_o = vec_word(pend[g]);
    end
  end

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (bus_rdata_o == '0));
  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !status_hit) |=> $stable(status) || ($past(evt_pulse_i) != '0));
  assert_decode_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({status_hit, mask_hit, vec_hit}) <= 1);
endmodule

// File: tb/evt_irq_aggregator_tb.sv
module evt_irq_aggregator_tb_top;
  import evt_agg_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TOTAL-1:0]  evt = '0;
  logic [7:0]        addr = '0;
  logic              wr = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_OUTS-1:0] irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  evt_irq_aggregator dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse_i (evt),
    .bus_addr_i  (addr),
    .bus_wr_i    (wr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, hold through the posedge
  task automatic cyc_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic pulse(input int n);
    evt = '0; evt[n] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  // op, addr / word index, data, expected
  localparam logic [1:0] OW = 2'd0, ORD = 2'd1, OE = 2'd2, OI = 2'd3;
  localparam int NSTEP = 32;
  localparam logic [73:0] STEPS [NSTEP] = '{
    {OW,  8'h10, 32'h0000_0001, 32'h0},            // R4 enable A word0 bit0
    {ORD, 8'h10, 32'h0, 32'h0000_0001},            // R4
    {OE,  8'h01, 32'h0000_0100, 32'h0},            // R1 event 40
    {ORD, 8'h04, 32'h0, 32'h0000_0100},            // R1
    {ORD, 8'h40, 32'h0, 32'h0},                    // R6 A has nothing enabled
    {OW,  8'h24, 32'h0000_0100, 32'h0},            // R4 enable B event 40
    {ORD, 8'h44, 32'h0, 32'h0000_00A8},            // R6 B vector = 40
    {OI,  8'h00, 32'h0, 32'h2},                    // R5 only B
    {OE,  8'h00, 32'h0000_0003, 32'h0},            // R1 events 0,1
    {ORD, 8'h00, 32'h0, 32'h0000_0003},            // R1
    {ORD, 8'h40, 32'h0, 32'h0000_0080},            // R6 A vector = 0
    {OI,  8'h00, 32'h0, 32'h3},                    // R5 A and B
    {OW,  8'h00, 32'h0000_0001, 32'h0},            // R2 ack event 0
    {ORD, 8'h00, 32'h0, 32'h0000_0002},            // R2
    {ORD, 8'h40, 32'h0, 32'h0},                    // R6 event 1 blocked
    {OI,  8'h00, 32'h0, 32'h2},                    // R5 A dropped
    {OE,  8'h02, 32'h8000_0000, 32'h0},            // R1 event 95
    {OW,  8'h38, 32'h8000_0000, 32'h0},            // R4 enable C event 95
    {ORD, 8'h48, 32'h0, 32'h0000_00DF},            // R6 C vector = 95
    {OI,  8'h00, 32'h0, 32'h6},                    // R5 B and C
    {OW,  8'h04, 32'h0000_0000, 32'h0},            // R2 zero write
    {ORD, 8'h04, 32'h0, 32'h0000_0100},            // R2 unchanged
    {OW,  8'h0C, 32'hFFFF_FFFF, 32'h0},            // R8 unmapped write
    {ORD, 8'h0C, 32'h0, 32'h0},                    // R8
    {OW,  8'h44, 32'h0000_00FF, 32'h0},            // R8 write to vector
    {ORD, 8'h44, 32'h0, 32'h0000_00A8},            // R8 unchanged
    {OW,  8'h08, 32'h8000_0000, 32'h0},            // R2 ack 95
    {OW,  8'h04, 32'h0000_0100, 32'h0},            // R2 ack 40
    {ORD, 8'h08, 32'h0, 32'h0},                    // R2
    {OI,  8'h00, 32'h0, 32'h0},                    // R5 all low
    {ORD, 8'h14, 32'h0, 32'h0},                    // R4 other word untouched
    {ORD, 8'h03, 32'h0, 32'h0}                     // R8 unaligned
  };

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    rd_check("R7 status0", 8'h00, 32'h0);
    rd_check("R7 mask C2", 8'h38, 32'h0);
    rd_check("R7 vec A", 8'h40, 32'h0);
    check("R7 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = STEPS[i];
      case (op)
        OW: begin addr = a; wr = 1'b1; wdata = d; end
        ORD: begin addr = a; #1; check($sformatf("table step %0d", i), rdata, e); end
        OE: begin evt = '0; evt[int'(a)*32 +: 32] = d; end
        default: begin #1; check($sformatf("table step %0d irq", i), 32'(irq), e); end
      endcase
      @(negedge clk);
      wr = 1'b0; evt = '0;
    end

    // R3: event and acknowledge on the same bit in one cycle
    pulse(5);
    rd_check("R3 pre", 8'h00, 32'h0000_0022);
    addr = 8'h00; wr = 1'b1; wdata = 32'h0000_0022; evt = '0; evt[5] = 1'b1;
    @(negedge clk);
    wr = 1'b0; evt = '0;
    rd_check("R3 event wins", 8'h00, 32'h0000_0020);

    // R5: one clock latency
    cyc_write(8'h10, 32'h0000_0080);
    @(negedge clk);
    check("R5 idle", 32'(irq), 32'h0);
    pulse(7);
    check("R5 not yet", 32'(irq[0]), 32'h0);
    @(negedge clk);
    check("R5 raised", 32'(irq[0]), 32'h1);

    // R6: priority across words
    cyc_write(8'h14, 32'h0000_0100);
    pulse(40);
    rd_check("R6 lowest 7", 8'h40, 32'h0000_0087);
    cyc_write(8'h00, 32'h0000_0080);
    rd_check("R6 next 40", 8'h40, 32'h0000_00A8);

    // R7: reset mid-run
    rst_n = 1'b0;
    #1;
    check("R7 irq after reset", 32'(irq), 32'h0);
    rd_check("R7 status1", 8'h04, 32'h0);
    rd_check("R7 mask A1", 8'h14, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule